// File: doc/BRIEF.md
# Chain-Link Cell Voltage Sorter and Carrier Allocator

This block keeps the storage capacitors of one series string of half-bridge cells close to each other in voltage. A snapshot of the measured cell voltages is taken on a sample tick. An iterative compare-exchange network then ranks the snapshot. Each cell gets a virtual index from its rank and the direction of the arm current. The index selects one band of a stack of in-phase triangle carriers. A cell is inserted while the arm reference lies above its band's carrier.

Each band is as tall as the voltage of the cell that currently owns it. So the stacked carriers track capacitor ripple, and the reference is compared against the voltage the string can actually produce.

A new ranking does not switch anything by itself. It waits until the number of inserted cells has to change, and is applied at that moment. Balancing therefore adds no switching events of its own. Every cell drives a complementary pair of gates: upper on inserts the capacitor, lower on bypasses it.

Top module: `cell_balance_alloc`

## Requirements
- R1: While reset is held and after it, every cell is bypassed: upper gate 0, lower gate 1. The band mapping is the identity, so cell i owns band i.
- R2: For every cell, the lower gate is always the complement of the upper gate.
- R3: A sample tick starts a sort of the voltages present at that tick. Equal voltages are ranked by lower cell number first. The ranking becomes available exactly N clock edges after the tick edge, and the mapping in use until then is the previous one.
- R4: With `arm_charging` = 1, the cell of rank r (rank 0 = lowest voltage) takes band r, so the lowest voltage gets the highest duty.
- R5: With `arm_charging` = 0, the cell of rank r takes band N-1-r, so the lowest voltage gets the lowest duty.
- R6: A ready ranking is applied only at a clock edge where the computed inserted count differs from the registered count. Each ranking is used at most once. While the count is unchanged, no gate changes.
- R7: Band k has base = sum of the amplitudes of bands 0..k-1. Its amplitude is the captured voltage of the cell owning band k. Its carrier is base + floor(amplitude * phase / 2^PW). Band k is inserted when `mod_ref` > carrier, and the inserted count is the number of inserted bands.
- R8: The shared carrier phase is 0 after reset. It rises by one per clock to 2^PW-1, then falls by one per clock to 0, and repeats.
- R9: The carrier amplitudes take the voltages captured at the latest sample tick from the very next cycle, without waiting for the sort.
- R10: With cells 0..5 at 1450, 1478, 1438, 1462, 1442 and 1455 and charging current, bands 0..5 are owned by cells 2, 4, 0, 5, 3 and 1.
- R11: The gate outputs are registered. At each edge, the cells whose band (under the mapping chosen at that edge) is below the newly computed count become inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_tick | input | 1 | Capture voltages and start a sort |
| cell_volt | input | N*VW | Measured cell voltages, cell i in slice i, unsigned |
| arm_charging | input | 1 | 1 when the arm current charges inserted cells |
| mod_ref | input | RW | Arm modulating reference, same scale as the voltages |
| gate_upper | output | N | Upper switch drive per cell, 1 = inserted |
| gate_lower | output | N | Lower switch drive per cell, 1 = bypassed |

## Verification
The bench targets tie ordering between equal voltages. A sorter that is not stable would hand the band to the wrong cell of a tied group, which shows up as a cell other than the highest-numbered one being inserted under discharging current.

It checks that a finished ranking stays unused while the inserted count holds. A design that applied it at once would move the inserted cell with no change in reference.

It checks that the amplitude snapshot is live one cycle after a tick. A design that waited for the sort would compute a smaller count at a low reference.

Both current directions are driven through a full staircase of references. A reversed direction rule or an off-by-one band base would insert the wrong cells at each step.

// File: rtl/cba_pkg.sv
`timescale 1ns/1ps
package cba_pkg;

    typedef enum logic {
        DIR_DISCHARGE = 1'b0,
        DIR_CHARGE    = 1'b1
    } arm_dir_e;

    // Ordering key: larger voltage first decides, then larger cell number.
    function automatic logic key_after(input int unsigned va, input int unsigned ia,
                                       input int unsigned vb, input int unsigned ib);
        return (va > vb) || ((va == vb) && (ia > ib));
    endfunction

endpackage

// File: rtl/cba_tri_phase.sv
`timescale 1ns/1ps
module cba_tri_phase #(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst,
    output logic [PW-1:0] phase_o
);
    localparam logic [PW-1:0] PTOP = '1;

    typedef struct packed {
        logic [PW-1:0] p;
        logic          rising;
    } tri_st_t;

    tri_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.rising) begin
            if (st_q.p == PTOP) begin
                st_d.rising = 1'b0;
                st_d.p      = st_q.p - 1'b1;
            end else begin
                st_d.p = st_q.p + 1'b1;
            end
        end else begin
            if (st_q.p == '0) begin
                st_d.rising = 1'b1;
                st_d.p      = st_q.p + 1'b1;
            end else begin
                st_d.p = st_q.p - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.p      <= '0;
            st_q.rising <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.p;
endmodule

// File: rtl/cba_sorter.sv
`timescale 1ns/1ps
module cba_sorter
    import cba_pkg::*;
#(
    parameter int N  = 6,
    parameter int VW = 16,
    parameter int IW = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_i,
    input  logic [N-1:0][VW-1:0]   samp_i,
    input  logic                   take_i,
    output logic [N-1:0][IW-1:0]   order_o,
    output logic                   ready_o,
    output logic                   busy_o
);
    localparam int CNTW = $clog2(N + 1);

    typedef struct packed {
        logic [N-1:0][VW-1:0] v;
        logic [N-1:0][IW-1:0] id;
        logic [N-1:0][IW-1:0] order;
        logic [CNTW-1:0]      cnt;
        logic                 ready;
    } sort_st_t;

    sort_st_t st_d, st_q;

    logic [N-1:0][VW-1:0] pv;
    logic [N-1:0][IW-1:0] pid;
    logic [CNTW-1:0]      pass_idx;
    logic                 odd_pass;

    // One odd-even transposition pass over the working array.
    always_comb begin
        pv       = st_q.v;
        pid      = st_q.id;
        pass_idx = CNTW'(N) - st_q.cnt;
        odd_pass = pass_idx[0];
        for (int a = 0; a < N - 1; a++) begin
            if (((a % 2) == int'(odd_pass)) &&
                key_after(int'(pv[a]), int'(pid[a]), int'(pv[a+1]), int'(pid[a+1]))) begin
                pv[a]    = st_q.v[a+1];
                pv[a+1]  = st_q.v[a];
                pid[a]   = st_q.id[a+1];
                pid[a+1] = st_q.id[a];
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (take_i) begin
            st_d.ready = 1'b0;
        end
        if (start_i) begin
            st_d.v   = samp_i;
            st_d.cnt = CNTW'(N);
            for (int i = 0; i < N; i++) begin
                st_d.id[i] = IW'(i);
            end
        end else if (st_q.cnt != '0) begin
            st_d.v   = pv;
            st_d.id  = pid;
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CNTW'(1)) begin
                st_d.order = pid;
                st_d.ready = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign order_o = st_q.order;
    assign ready_o = st_q.ready;
    assign busy_o  = (st_q.cnt != '0);
endmodule

// File: rtl/cba_band_stack.sv
`timescale 1ns/1ps
module cba_band_stack #(
    parameter int N  = 6,
    parameter int VW = 16,
    parameter int IW = 3,
    parameter int PW = 4,
    parameter int RW = 19,
    parameter int CW = 3
) (
    input  logic [N-1:0][VW-1:0] samp_i,
    input  logic [N-1:0][IW-1:0] owner_i,
    input  logic [PW-1:0]        phase_i,
    input  logic [RW-1:0]        ref_i,
    output logic [CW-1:0]        count_o
);
    localparam int PRW = VW + PW;

    logic [RW-1:0]  base;
    logic [RW-1:0]  carrier;
    logic [VW-1:0]  amp;
    logic [PRW-1:0] prod;
    logic [CW-1:0]  cnt;

    // Bands are evaluated bottom-up; each band sits on the sum of those below.
    always_comb begin
        base    = '0;
        cnt     = '0;
        amp     = '0;
        prod    = '0;
        carrier = '0;
        for (int k = 0; k < N; k++) begin
            amp     = samp_i[owner_i[k]];
            prod    = PRW'(amp) * PRW'(phase_i);
            carrier = base + RW'(prod >> PW);
            if (ref_i > carrier) begin
                cnt = cnt + CW'(1);
            end
            base = base + RW'(amp);
        end
        count_o = cnt;
    end
endmodule

// File: rtl/cell_balance_alloc.sv
`timescale 1ns/1ps
module cell_balance_alloc
    import cba_pkg::*;
#(
    parameter int N  = 6,
    parameter int VW = 16,
    parameter int PW = 4,
    localparam int RW = VW + $clog2(N + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sample_tick,
    input  logic [N-1:0][VW-1:0] cell_volt,
    input  logic                 arm_charging,
    input  logic [RW-1:0]        mod_ref,
    output logic [N-1:0]         gate_upper,
    output logic [N-1:0]         gate_lower
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam int CW = $clog2(N + 1);

    typedef struct packed {
        logic [N-1:0][VW-1:0] samp;
        logic [N-1:0][IW-1:0] owner;
        logic [CW-1:0]        count;
        logic [N-1:0]         gates;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [PW-1:0]        phase_q;
    logic [N-1:0][IW-1:0] order;
    logic                 sort_ready;
    logic                 sort_busy;
    logic                 take;
    logic [CW-1:0]        cnt_new;
    logic [CW-1:0]        ins_count_q;
    logic [N-1:0][IW-1:0] band_of;
    arm_dir_e             dir;

    cba_tri_phase #(.PW(PW)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .phase_o (phase_q)
    );

    cba_sorter #(.N(N), .VW(VW), .IW(IW)) u_sort (
        .clk     (clk),
        .rst     (rst),
        .start_i (sample_tick),
        .samp_i  (cell_volt),
        .take_i  (take),
        .order_o (order),
        .ready_o (sort_ready),
        .busy_o  (sort_busy)
    );

    cba_band_stack #(.N(N), .VW(VW), .IW(IW), .PW(PW), .RW(RW), .CW(CW)) u_stack (
        .samp_i  (st_q.samp),
        .owner_i (st_q.owner),
        .phase_i (phase_q),
        .ref_i   (mod_ref),
        .count_o (cnt_new)
    );

    assign dir  = arm_dir_e'(arm_charging);
    assign take = sort_ready && (cnt_new != st_q.count);

    always_comb begin
        st_d    = st_q;
        band_of = '0;
        if (take) begin
            for (int r = 0; r < N; r++) begin
                if (dir == DIR_CHARGE) begin
                    st_d.owner[r] = order[r];
                end else begin
                    st_d.owner[N-1-r] = order[r];
                end
            end
        end
        for (int k = 0; k < N; k++) begin
            band_of[st_d.owner[k]] = IW'(k);
        end
        for (int i = 0; i < N; i++) begin
            st_d.gates[i] = (int'(band_of[i]) < int'(cnt_new));
        end
        st_d.count = cnt_new;
        if (sample_tick) begin
            st_d.samp = cell_volt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.samp  <= '0;
            st_q.count <= '0;
            st_q.gates <= '0;
            for (int k = 0; k < N; k++) begin
                st_q.owner[k] <= IW'(k);
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign ins_count_q = st_q.count;
    assign gate_upper  = st_q.gates;
    assign gate_lower  = ~st_q.gates;
endmodule

// File: rtl/cba_checker.sv
`timescale 1ns/1ps
module cba_checker #(
    parameter int N  = 6,
    parameter int CW = 3,
    parameter int PW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic [N-1:0]  gate_upper,
    input logic [CW-1:0] ins_count,
    input logic [PW-1:0] phase,
    input logic          sort_busy,
    input logic          sort_ready
);
    // R1: one edge of reset leaves every cell bypassed
    assert_bypass_on_reset_R1: assert property (@(posedge clk)
        rst |=> (gate_upper == '0));

    // R7: number of inserted cells equals the registered band count
    assert_count_match_R7: assert property (@(posedge clk) disable iff (rst)
        $countones(gate_upper) == int'(ins_count));

    // R6: no gate moves while the inserted count holds
    assert_hold_between_switches_R6: assert property (@(posedge clk) disable iff (rst)
        $stable(ins_count) |-> $stable(gate_upper));

    // R8: the carrier phase moves by exactly one step per clock
    assert_phase_step_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((phase == PW'($past(phase) + 1'b1)) ||
                         ($past(phase) == PW'(phase + 1'b1))));

    // R3: a ranking becomes ready only at the end of a running sort
    assert_ready_after_sort_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(sort_ready) |-> $past(sort_busy));
endmodule

bind cell_balance_alloc cba_checker #(.N(N), .CW(CW), .PW(PW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .gate_upper (gate_upper),
    .ins_count  (ins_count_q),
    .phase      (phase_q),
    .sort_busy  (sort_busy),
    .sort_ready (sort_ready)
);

// File: tb/cell_balance_alloc_bench.sv
`timescale 1ns/1ps
module cell_balance_alloc_bench;
    localparam int N  = 6;
    localparam int VW = 16;
    localparam int PW = 4;
    localparam int RW = VW + $clog2(N + 1);
    localparam int PTOP = (1 << PW) - 1;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 sample_tick = 1'b0;
    logic [N-1:0][VW-1:0] cell_volt = '0;
    logic                 arm_charging = 1'b1;
    logic [RW-1:0]        mod_ref = '0;
    logic [N-1:0]         gate_upper;
    logic [N-1:0]         gate_lower;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    cell_balance_alloc #(.N(N), .VW(VW), .PW(PW)) u_cell_balance_alloc (
        .clk          (clk),
        .rst          (rst),
        .sample_tick  (sample_tick),
        .cell_volt    (cell_volt),
        .arm_charging (arm_charging),
        .mod_ref      (mod_ref),
        .gate_upper   (gate_upper),
        .gate_lower   (gate_lower)
    );

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Behavioural reference model, evaluated at every rising edge.
    int       m_samp[N];
    int       m_owner[N];
    int       m_pend[N];
    int       m_snap[N];
    bit       m_ready;
    int       m_left;
    int       m_count;
    int       m_p;
    bit       m_up;
    bit [N-1:0] m_gates;

    function automatic int model_count();
        longint base = 0;
        int     c = 0;
        for (int k = 0; k < N; k++) begin
            longint amp = m_samp[m_owner[k]];
            longint car = base + ((amp * m_p) >> PW);
            if (longint'(mod_ref) > car) c++;
            base += amp;
        end
        return c;
    endfunction

    function automatic void model_rank();
        int q[$];
        bit used[N];
        for (int i = 0; i < N; i++) used[i] = 0;
        for (int r = 0; r < N; r++) begin
            int best = -1;
            for (int i = 0; i < N; i++) begin
                if (!used[i] && (best < 0 || m_snap[i] < m_snap[best])) best = i;
            end
            used[best] = 1;
            q.push_back(best);
        end
        for (int r = 0; r < N; r++) m_pend[r] = q[r];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_samp[i] = 0; m_owner[i] = i; m_pend[i] = 0; m_snap[i] = 0;
            end
            m_ready = 0; m_left = 0; m_count = 0; m_p = 0; m_up = 1; m_gates = '0;
        end else begin
            int  cn;
            bit  tk;
            int  bnd[N];
            cn = model_count();
            tk = m_ready && (cn != m_count);
            if (tk) begin
                for (int r = 0; r < N; r++) begin
                    if (arm_charging) m_owner[r] = m_pend[r];
                    else              m_owner[N-1-r] = m_pend[r];
                end
                m_ready = 0;
            end
            if (sample_tick) begin
                for (int i = 0; i < N; i++) m_snap[i] = int'(cell_volt[i]);
                m_left = N;
            end else if (m_left > 0) begin
                m_left--;
                if (m_left == 0) begin
                    model_rank();
                    m_ready = 1;
                end
            end
            for (int k = 0; k < N; k++) bnd[m_owner[k]] = k;
            for (int i = 0; i < N; i++) m_gates[i] = (bnd[i] < cn);
            m_count = cn;
            if (sample_tick) begin
                for (int i = 0; i < N; i++) m_samp[i] = int'(cell_volt[i]);
            end
            if (m_up) begin
                if (m_p == PTOP) begin m_up = 0; m_p = PTOP - 1; end
                else m_p++;
            end else begin
                if (m_p == 0) begin m_up = 1; m_p = 1; end
                else m_p--;
            end
        end
    end

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        if (!rst) begin
            chk(gate_upper == m_gates, "R4 R5 R6 R7 R8 R9 R11 model compare",
                longint'(gate_upper), longint'(m_gates));
            chk(gate_lower == ~gate_upper, "R2 complementary gates",
                longint'(gate_lower), longint'(~gate_upper));
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; sample_tick = 1'b0; mod_ref = '0;
        step(3);
        chk(gate_upper == '0, "R1 upper gates in reset", longint'(gate_upper), 0);
        chk(gate_lower == '1, "R1 lower gates in reset", longint'(gate_lower), (1 << N) - 1);
        rst = 1'b0;
    endtask

    task automatic load_example();
        cell_volt[0] = 16'd1450; cell_volt[1] = 16'd1478; cell_volt[2] = 16'd1438;
        cell_volt[3] = 16'd1462; cell_volt[4] = 16'd1442; cell_volt[5] = 16'd1455;
    endtask

    task automatic expect_gates(input int refv, input logic [N-1:0] exp, input string what);
        mod_ref = RW'(refv);
        step(1);
        chk(gate_upper == exp, what, longint'(gate_upper), longint'(exp));
    endtask

    initial begin
        int cyc;
        int rdir;
        do_reset();

        // Charging, example voltages
        arm_charging = 1'b1;
        load_example();
        sample_tick = 1'b1; step(1); sample_tick = 1'b0;
        expect_gates(1450, 6'b000001, "R1 R3 identity mapping before sort completes");
        step(N + 2);
        chk(gate_upper == 6'b000001, "R6 ready ranking unused while count holds",
            longint'(gate_upper), 1);
        expect_gates(0, 6'b000000, "R6 switch to zero inserted");
        expect_gates(1438, 6'b000100, "R4 R10 band 0 owned by cell 2");
        expect_gates(2880, 6'b010100, "R10 bands 0-1");
        expect_gates(4330, 6'b010101, "R10 bands 0..2");
        expect_gates(5785, 6'b110101, "R10 bands 0..3");
        expect_gates(7247, 6'b111101, "R10 bands 0..4");
        expect_gates(8725, 6'b111111, "R10 all bands");

        // Discharging, example voltages
        do_reset();
        arm_charging = 1'b0;
        load_example();
        sample_tick = 1'b1; step(1); sample_tick = 1'b0;
        step(N + 3);
        expect_gates(1450, 6'b000010, "R5 band 0 owned by highest voltage cell 1");
        expect_gates(2940, 6'b001010, "R5 bands 0..1");
        expect_gates(4395, 6'b101010, "R5 bands 0..2");
        expect_gates(5845, 6'b101011, "R5 bands 0..3");
        expect_gates(7287, 6'b111011, "R5 bands 0..4");
        expect_gates(8725, 6'b111111, "R5 all bands");

        // Equal voltages, discharging
        do_reset();
        arm_charging = 1'b0;
        for (int i = 0; i < N; i++) cell_volt[i] = 16'd1000;
        sample_tick = 1'b1; step(1); sample_tick = 1'b0;
        step(N + 3);
        expect_gates(1000, 6'b100000, "R3 tie order puts cell 5 on band 0");
        expect_gates(2000, 6'b110000, "R3 tie order cell 4 on band 1");

        // Amplitude follows capture at once
        expect_gates(0, 6'b000000, "R6 back to zero inserted");
        cell_volt[4] = 16'd100; cell_volt[5] = 16'd100;
        sample_tick = 1'b1; step(1); sample_tick = 1'b0;
        expect_gates(199, 6'b110000, "R9 captured amplitudes used next cycle");

        // Random operation against the model
        do_reset();
        cyc = 0;
        rdir = 1;
        for (int it = 0; it < 24000; it++) begin
            if ((it % 3000) == 0) arm_charging = ~arm_charging;
            sample_tick = ($urandom_range(0, 149) == 0);
            if (sample_tick) begin
                for (int i = 0; i < N; i++) cell_volt[i] = VW'($urandom_range(900, 2100));
            end
            cyc = cyc + rdir * int'($urandom_range(0, 40));
            if (cyc > 13000) begin cyc = 13000; rdir = -1; end
            if (cyc < 0) begin cyc = 0; rdir = 1; end
            mod_ref = RW'(cyc);
            step(1);
        end
        sample_tick = 1'b0;
        step(2);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule